// File: doc/BRIEF.md
# SPI Codec Control Register Port

This block is the write-only serial control port of an audio converter. A host lowers chip select, sends bits on a data line and toggles a bit clock. The block checks a fixed 7-bit device identifier and a direction bit. It then takes a pointer byte, which names a register and can turn on automatic address stepping. Every complete byte after the pointer is written into the addressed register. Five 8-bit registers (addresses 00h to 04h) are held here, and their fields are presented as decoded outputs.

The block runs on a fast system clock. The serial inputs are treated as already synchronised to it, and edges are found by comparing each sample with the previous one. The port stays in a disabled state after reset. It opens on the first falling edge of chip select and stays open until the next reset.

Top module: `codec_ctl_spi_port`

## Requirements
- R1: While reset is asserted, and after it is released, the register contents are 00h=00h, 01h=83h, 02h=49h, 03h=00h and 04h=00h.
- R2: While chip select is low, a bit is taken from the data line on every rising bit-clock edge, most significant bit first. The first byte of a frame is the identifier 0010000 in bits 7:1 followed by bit 0 = 0 (write), so the header byte is 20h.
- R3: If the header byte is not 20h, because the identifier differs or bit 0 is 1, no register changes for the rest of that frame.
- R4: In the second byte, bit 7 is the step enable and bits 6:0 are the register address. With step enable at 0, every data byte in the frame writes the same register.
- R5: With step enable at 1, the address rises by one after each data byte.
- R6: Register 01h drives, from bit 7 down to bit 0: the auto-mute enable, a 3-bit format field, a 2-bit de-emphasis field, the ramp enable and the power-down bit.
- R7: Register 02h drives, from bit 7 down: the channel-link bit, a 2-bit change-mode field and a 5-bit mixing field. Registers 03h and 04h each drive a mute bit (bit 7) and a 7-bit volume field (bits 6:0) for channels A and B. Register 00h is driven out whole.
- R8: When chip select rises before the eighth bit of a byte, that partial byte is dropped. The next frame starts cleanly with a header byte.
- R9: A data byte sent to an address from 05h to 7Fh changes no register.
- R10: The port output is 0 and all bits are ignored until chip select first goes from high to low after reset. From then on it is 1 until reset.
- R11: Asserting reset in the middle of operation restores every register to its R1 value and clears the port-open state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sck | input | 1 | Serial bit clock, synchronous to clk |
| sdi | input | 1 | Serial data input |
| port_open | output | 1 | Serial port has been selected since reset |
| clk_cfg | output | 8 | Contents of register 00h |
| auto_mute_en | output | 1 | Auto-mute enable (01h bit 7) |
| fmt_sel | output | 3 | Interface format field (01h bits 6:4) |
| deemph_sel | output | 2 | De-emphasis select (01h bits 3:2) |
| ramp_en | output | 1 | Output voltage ramp enable (01h bit 1) |
| power_down | output | 1 | Power-down request (01h bit 0) |
| vol_link | output | 1 | Channel A volume drives both channels (02h bit 7) |
| change_mode | output | 2 | Level change mode (02h bits 6:5) |
| mix_sel | output | 5 | Channel mixing select (02h bits 4:0) |
| mute_a | output | 1 | Channel A mute (03h bit 7) |
| vol_a | output | 7 | Channel A attenuation (03h bits 6:0) |
| mute_b | output | 1 | Channel B mute (04h bit 7) |
| vol_b | output | 7 | Channel B attenuation (04h bits 6:0) |

## Verification
The assertions assume that cs_n, sck and sdi are already synchronous to clk. They also assume each level of sck lasts at least one clk cycle, so every bit-clock rise is seen exactly once, and that sdi is stable when sck rises. The stimulus keeps each bit-clock phase two system cycles long and changes data only while sck is low. It moves chip select only while sck is low and never in the same cycle as a bit-clock rise.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        FR_HDR  = 2'd0,
        FR_PTR  = 2'd1,
        FR_DATA = 2'd2,
        FR_SKIP = 2'd3
    } frame_st_e;

    function automatic logic [BYTE_W-1:0] reg_reset_val(input int idx);
        case (idx)
            1:       return 8'h83;
            2:       return 8'h49;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/codec_ctl_edges.sv
module codec_ctl_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic sck_rise,
    output logic cs_fall,
    output logic port_open
);
    typedef struct packed {
        logic sck_prev;
        logic cs_prev;
        logic open;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck;
        st_d.cs_prev  = cs_n;
        if (!cs_n && st_q.cs_prev) begin
            st_d.open = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sck_prev <= 1'b1;
            st_q.cs_prev  <= 1'b0;
            st_q.open     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_rise  = sck && !st_q.sck_prev;
    assign cs_fall   = !cs_n && st_q.cs_prev;
    assign port_open = st_q.open;

    p_open_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        port_open |=> port_open);

    p_open_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !port_open && !cs_fall |=> !port_open);

endmodule

// File: rtl/codec_ctl_frame.sv
module codec_ctl_frame
    import codec_ctl_pkg::*;
#(
    parameter int         ID_W    = 7,
    parameter logic [6:0] CHIP_ID = 7'b0010000,
    parameter int         PTR_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sdi,
    input  logic             sck_rise,
    input  logic             port_open,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        frame_st_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic [PTR_W-1:0]   ptr;
        logic               inc;
    } frame_t;

    frame_t fr_d, fr_q;
    logic [BYTE_W-1:0] byte_v;
    logic              hdr_ok;

    assign byte_v = {fr_q.sh[BYTE_W-2:0], sdi};
    assign hdr_ok = (byte_v[BYTE_W-1 -: ID_W] == CHIP_ID) && !byte_v[0];

    always_comb begin
        fr_d  = fr_q;
        wr_en = 1'b0;
        if (cs_n) begin
            fr_d.st  = FR_HDR;
            fr_d.cnt = '0;
        end else if (port_open && sck_rise) begin
            fr_d.sh  = byte_v;
            fr_d.cnt = fr_q.cnt + 1'b1;
            if (fr_q.cnt == LAST_BIT) begin
                fr_d.cnt = '0;
                case (fr_q.st)
                    FR_HDR:  fr_d.st = hdr_ok ? FR_PTR : FR_SKIP;
                    FR_PTR: begin
                        fr_d.ptr = byte_v[PTR_W-1:0];
                        fr_d.inc = byte_v[BYTE_W-1];
                        fr_d.st  = FR_DATA;
                    end
                    FR_DATA: begin
                        wr_en = 1'b1;
                        if (fr_q.inc) begin
                            fr_d.ptr = fr_q.ptr + 1'b1;
                        end
                    end
                    default: fr_d.st = FR_SKIP;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{st: FR_HDR, cnt: '0, sh: '0, ptr: '0, inc: 1'b0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign wr_addr = fr_q.ptr;
    assign wr_data = byte_v;

    p_write_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sck_rise && !cs_n && port_open);

    p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.st == FR_SKIP |-> !wr_en);

    p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !fr_q.inc |=> $stable(wr_addr));

    p_step_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && fr_q.inc |=> wr_addr == $past(wr_addr) + 1'b1);

    p_cs_high_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> fr_q.cnt == '0 && fr_q.st == FR_HDR);

endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
    import codec_ctl_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int PTR_W    = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [PTR_W-1:0]                 wr_addr,
    input  logic [BYTE_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs
);
    typedef struct packed {
        logic [NUM_REGS-1:0][BYTE_W-1:0] r;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  in_range;

    assign in_range = int'(wr_addr) < NUM_REGS;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && in_range && int'(wr_addr) == i) begin
                bank_d.r[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                bank_q.r[i] <= reg_reset_val(i);
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs = bank_q.r;

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    p_out_of_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !in_range |=> $stable(regs));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && in_range |=> regs[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/codec_ctl_spi_port.sv
module codec_ctl_spi_port
    import codec_ctl_pkg::*;
#(
    parameter logic [6:0] CHIP_ID = 7'b0010000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       sdi,
    output logic       port_open,
    output logic [7:0] clk_cfg,
    output logic       auto_mute_en,
    output logic [2:0] fmt_sel,
    output logic [1:0] deemph_sel,
    output logic       ramp_en,
    output logic       power_down,
    output logic       vol_link,
    output logic [1:0] change_mode,
    output logic [4:0] mix_sel,
    output logic       mute_a,
    output logic [6:0] vol_a,
    output logic       mute_b,
    output logic [6:0] vol_b
);
    localparam int REG_COUNT = 5;
    localparam int PTR_W     = 7;

    logic                               sck_rise;
    logic                               cs_fall;
    logic                               wr_en;
    logic [PTR_W-1:0]                   wr_addr;
    logic [BYTE_W-1:0]                  wr_data;
    logic [REG_COUNT-1:0][BYTE_W-1:0]   regs;

    codec_ctl_edges i_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .sck_rise  (sck_rise),
        .cs_fall   (cs_fall),
        .port_open (port_open)
    );

    codec_ctl_frame #(
        .ID_W    (7),
        .CHIP_ID (CHIP_ID),
        .PTR_W   (PTR_W)
    ) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sck_rise  (sck_rise),
        .port_open (port_open),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    codec_ctl_regs #(
        .NUM_REGS (REG_COUNT),
        .PTR_W    (PTR_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs    (regs)
    );

    assign clk_cfg                                                   = regs[0];
    assign {auto_mute_en, fmt_sel, deemph_sel, ramp_en, power_down}  = regs[1];
    assign {vol_link, change_mode, mix_sel}                          = regs[2];
    assign {mute_a, vol_a}                                           = regs[3];
    assign {mute_b, vol_b}                                           = regs[4];

    p_no_write_before_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !port_open |-> !wr_en);

    p_fall_opens_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> port_open);

endmodule

// File: tb/test_codec_ctl_spi_port.sv
module test_codec_ctl_spi_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       port_open;
    logic [7:0] clk_cfg;
    logic       auto_mute_en;
    logic [2:0] fmt_sel;
    logic [1:0] deemph_sel;
    logic       ramp_en;
    logic       power_down;
    logic       vol_link;
    logic [1:0] change_mode;
    logic [4:0] mix_sel;
    logic       mute_a;
    logic [6:0] vol_a;
    logic       mute_b;
    logic [6:0] vol_b;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    codec_ctl_spi_port i_codec_ctl_spi_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .port_open(port_open), .clk_cfg(clk_cfg), .auto_mute_en(auto_mute_en),
        .fmt_sel(fmt_sel), .deemph_sel(deemph_sel), .ramp_en(ramp_en),
        .power_down(power_down), .vol_link(vol_link), .change_mode(change_mode),
        .mix_sel(mix_sel), .mute_a(mute_a), .vol_a(vol_a), .mute_b(mute_b),
        .vol_b(vol_b)
    );

    // Register images rebuilt from the decoded field outputs
    function automatic logic [7:0] img(input int idx);
        case (idx)
            0:       return clk_cfg;
            1:       return {auto_mute_en, fmt_sel, deemph_sel, ramp_en, power_down};
            2:       return {vol_link, change_mode, mix_sel};
            3:       return {mute_a, vol_a};
            default: return {mute_b, vol_b};
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_regs[5];
    int m_st, m_cnt, m_sh, m_ptr, m_inc, m_open, m_prev_sck, m_prev_cs;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_regs = '{0, 'h83, 'h49, 0, 0};
            m_st = 0; m_cnt = 0; m_sh = 0; m_ptr = 0; m_inc = 0;
            m_open = 0; m_prev_sck = 1; m_prev_cs = 0;
        end else begin
            if (cs_n) begin
                m_st = 0; m_cnt = 0;
            end else if (m_open != 0 && sck && m_prev_sck == 0) begin
                m_sh = ((m_sh << 1) | int'(sdi)) & 255;
                m_cnt++;
                if (m_cnt == 8) begin
                    m_cnt = 0;
                    if (m_st == 0) m_st = (m_sh == 'h20) ? 1 : 3;
                    else if (m_st == 1) begin
                        m_ptr = m_sh & 127; m_inc = m_sh >> 7; m_st = 2;
                    end else if (m_st == 2) begin
                        if (m_ptr < 5) m_regs[m_ptr] = m_sh;
                        if (m_inc != 0) m_ptr = (m_ptr + 1) & 127;
                    end
                end
            end
            if (!cs_n && m_prev_cs != 0) m_open = 1;
            m_prev_sck = int'(sck);
            m_prev_cs  = int'(cs_n);
        end
    end

    // Compare every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R10 port_open", int'(port_open), m_open);
            check("R2 reg00", int'(img(0)), m_regs[0]);
            check("R6 reg01", int'(img(1)), m_regs[1]);
            check("R7 reg02", int'(img(2)), m_regs[2]);
            check("R7 reg03", int'(img(3)), m_regs[3]);
            check("R7 reg04", int'(img(4)), m_regs[4]);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        tick(2);
        sck = 1'b1;
        tick(2);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic frame(input logic [7:0] hdr, input logic [7:0] ptr,
                         input int n, input logic [7:0] d0,
                         input logic [7:0] d1, input logic [7:0] d2);
        cs_n = 1'b0;
        tick(2);
        send_byte(hdr);
        send_byte(ptr);
        if (n > 0) send_byte(d0);
        if (n > 1) send_byte(d1);
        if (n > 2) send_byte(d2);
        tick(2);
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        tick(3);
        // R1: values while reset is asserted
        check("R1 reg01 in reset", int'(img(1)), 'h83);
        check("R1 reg02 in reset", int'(img(2)), 'h49);
        check("R1 reg03 in reset", int'(img(3)), 0);
        rst_n = 1'b1;
        tick(2);
        check("R1 reg00 default", int'(img(0)), 0);
        check("R1 reg04 default", int'(img(4)), 0);

        // R10: chip select low since reset, no falling edge yet
        send_byte(8'h20); send_byte(8'h03); send_byte(8'h55);
        tick(2);
        check("R10 closed port ignores bits", int'(img(3)), 0);
        check("R10 still closed", int'(port_open), 0);
        cs_n = 1'b1;
        tick(3);

        // R2 / R7: plain write to channel A volume
        frame(8'h20, 8'h03, 1, 8'hA5, 8'h00, 8'h00);
        check("R10 opened", int'(port_open), 1);
        check("R7 mute_a", int'(mute_a), 1);
        check("R7 vol_a", int'(vol_a), 'h25);

        // R6: mode register decode
        frame(8'h20, 8'h01, 1, 8'h5C, 8'h00, 8'h00);
        check("R6 fmt_sel", int'(fmt_sel), 5);
        check("R6 deemph_sel", int'(deemph_sel), 3);
        check("R6 power_down", int'(power_down), 0);

        // R4: no stepping, two bytes to the same register
        frame(8'h20, 8'h04, 2, 8'h11, 8'h22, 8'h00);
        check("R4 last byte wins", int'(img(4)), 'h22);
        check("R4 neighbour untouched", int'(img(3)), 'hA5);

        // R5: stepping across 01h..03h
        frame(8'h20, 8'h81, 3, 8'h12, 8'h34, 8'h56);
        check("R5 reg01", int'(img(1)), 'h12);
        check("R5 reg02", int'(img(2)), 'h34);
        check("R5 reg03", int'(img(3)), 'h56);
        check("R7 change_mode", int'(change_mode), 1);

        // R3: wrong identifier, then read direction
        frame(8'h22, 8'h02, 1, 8'h00, 8'h00, 8'h00);
        check("R3 bad id ignored", int'(img(2)), 'h34);
        frame(8'h21, 8'h02, 1, 8'h00, 8'h00, 8'h00);
        check("R3 read bit ignored", int'(img(2)), 'h34);

        // R9: out-of-range addresses, stepping past the top
        frame(8'h20, 8'h05, 1, 8'hFF, 8'h00, 8'h00);
        frame(8'h20, 8'h84, 2, 8'h0F, 8'hF0, 8'h00);
        check("R9 reg04 from step", int'(img(4)), 'h0F);
        check("R9 reg00 untouched", int'(img(0)), 0);
        frame(8'h20, 8'h00, 1, 8'h01, 8'h00, 8'h00);
        check("R7 clk_cfg", int'(clk_cfg), 1);

        // R8: partial byte dropped at chip select rise
        cs_n = 1'b0;
        tick(2);
        send_byte(8'h20); send_byte(8'h03);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        tick(2);
        cs_n = 1'b1;
        tick(3);
        check("R8 partial dropped", int'(img(3)), 'h56);
        frame(8'h20, 8'h03, 1, 8'h07, 8'h00, 8'h00);
        check("R8 next frame clean", int'(img(3)), 'h07);

        // R11: reset in the middle of a frame
        cs_n = 1'b0;
        tick(2);
        send_byte(8'h20);
        rst_n = 1'b0;
        tick(2);
        check("R11 reg03 restored", int'(img(3)), 0);
        check("R11 reg01 restored", int'(img(1)), 'h83);
        check("R11 port closed", int'(port_open), 0);
        cs_n = 1'b1;
        rst_n = 1'b1;
        tick(4);
        check("R11 reg02 restored", int'(img(2)), 'h49);

        finish_run();
    end

endmodule